// File: doc/BRIEF.md
# Strobed Supply Divider Monitor

This block keeps an external resistor divider and its over/undervoltage comparators asleep nearly all the time. While monitoring is enabled it closes the divider's ground switch and wakes the comparators for a short window at the start of every period. The default is 200 µs out of every 10 ms, counted in microsecond ticks, which is a 2 % duty cycle. The comparator levels are taken only on the tick that ends the window. A violation found there sets a fault flag that stays set until a later window samples a clean supply. After each capture a one-cycle valid pulse tells downstream control that a fresh verdict is ready.

There are two undervoltage comparators, and the block picks one of them from the state of the external switch gate. The high-UV comparator decides while the gate is off and the low-UV comparator decides while the gate is on, which gives a higher turn-on threshold than turn-off threshold. The enable input already combines the shutdown pin with the supply lockout condition. When it drops, the divider is released, the fault is cleared and the period counter returns to zero.

Top module: `strobe_monitor`

## Requirements
- R1: During and right after reset, div_gnd_en, cmp_wake, volt_fault and sample_valid are all 0.
- R2: While enabled, div_gnd_en and cmp_wake are both 1 for exactly STROBE_TICKS ticks from the start of each period and 0 for the rest of the period.
- R3: While enabled, a new window starts every PERIOD_TICKS ticks.
- R4: Only cycles with us_tick = 1 advance the period. With no ticks, the window stays open and no capture happens.
- R5: Comparator levels count only on the tick that ends a window. Levels at any other time have no effect on volt_fault.
- R6: A UV comparator input of 1 means the supply is above that threshold. The block checks cmp_uv_hi when gate_high = 0 and cmp_uv_lo when gate_high = 1. A 0 on the selected input is a violation.
- R7: cmp_ov = 1 at capture is a violation whatever the gate state.
- R8: volt_fault takes the capture's verdict in the cycle after the window's last tick. Otherwise it holds, so a fault lasts until a later capture is clean.
- R9: sample_valid is 1 for exactly one cycle, the cycle after each capture.
- R10: mon_enable is registered once. One cycle after it falls, the window outputs go to 0, and one cycle after that volt_fault is 0. Once it rises again, the window opens in the first cycle after the register sees the 1, with the period counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| mon_enable | input | 1 | Monitoring allowed (enabled and supply above lockout) |
| gate_high | input | 1 | External switch gate is on |
| cmp_uv_lo | input | 1 | Turn-off UV comparator, 1 = above threshold |
| cmp_uv_hi | input | 1 | Turn-on UV comparator, 1 = above threshold |
| cmp_ov | input | 1 | OV comparator, 1 = overvoltage |
| div_gnd_en | output | 1 | Closes the divider ground switch |
| cmp_wake | output | 1 | Wakes the comparators |
| volt_fault | output | 1 | Latched voltage fault |
| sample_valid | output | 1 | One-cycle pulse after each capture |

## Verification
A wrong phase count shows up at the ports at once: the window length on div_gnd_en is wrong in the first period, or the window spacing is wrong by the start of the second. A capture on the wrong tick, or a wrong UV selection, shows on volt_fault in the cycle after the first window closes. A fault register that does not hold or does not clear shows within one period, at the next capture. A counter that is not reset on disable shows as a missing window in the first cycle after re-enable.

// File: rtl/strobe_pkg.sv
// Shared types for the strobed divider monitor.
// Assumes comparator levels are already synchronous to clk.
package strobe_pkg;

    // Digital comparator levels seen while the divider is powered
    typedef struct packed {
        logic uv_lo;   // 1 = above the turn-off UV threshold
        logic uv_hi;   // 1 = above the turn-on UV threshold
        logic ov;      // 1 = above the OV threshold
    } cmp_levels_t;

    // Violation verdict: OV always counts, UV input chosen by gate state
    function automatic logic violation_of(input cmp_levels_t lv, input logic gate_on);
        logic uv_ok;
        uv_ok = gate_on ? lv.uv_lo : lv.uv_hi;
        return lv.ov | ~uv_ok;
    endfunction

endpackage

// File: rtl/strobe_sequencer.sv
// Period and window sequencer. It counts microsecond ticks in a modulo
// PERIOD_TICKS phase counter and opens the window for the first
// STROBE_TICKS of each period. It flags the tick that closes the window.
// Assumes 1 <= STROBE_TICKS < PERIOD_TICKS and PERIOD_TICKS >= 2.
module strobe_sequencer #(
    parameter int PERIOD_TICKS = 10000,
    parameter int STROBE_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic mon_enable,
    output logic run,
    output logic window,
    output logic win_end
);
    localparam int PW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [PW-1:0] LAST_PHASE = PW'(PERIOD_TICKS - 1);
    localparam logic [PW-1:0] WIN_LAST   = PW'(STROBE_TICKS - 1);
    localparam logic [PW-1:0] WIN_LEN    = PW'(STROBE_TICKS);

    logic [PW-1:0] phase;

    // Register the enable condition so every downstream decision uses one edge
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= mon_enable;
    end

    // Phase counter: held at zero while idle, wraps at the end of each period
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  phase <= '0;
        else if (us_tick)    phase <= (phase == LAST_PHASE) ? '0 : phase + 1'b1;
    end

    // Window decode and end-of-window capture strobe
    always_comb begin
        window  = run && (phase < WIN_LEN);
        win_end = run && us_tick && (phase == WIN_LAST);
    end
endmodule

// File: rtl/uv_fault_eval.sv
// Combinational verdict on the comparator levels. It selects the UV
// comparator from the gate state and merges in the OV comparator.
// Assumes the levels are stable by the end of the window.
module uv_fault_eval
    import strobe_pkg::*;
(
    input  cmp_levels_t levels,
    input  logic        gate_high,
    output logic        violation
);
    // Threshold selection: turn-on level while off, turn-off level while on
    always_comb violation = violation_of(levels, gate_high);
endmodule

// File: rtl/fault_capture.sv
// Holds the voltage-fault verdict. It loads only on the window-end
// strobe, raises a one-cycle valid pulse after each load, and clears
// when monitoring is idle.
module fault_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic win_end,
    input  logic violation,
    output logic fault,
    output logic valid
);
    // Capture at window end; hold otherwise; clear while idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            fault <= 1'b0;
            valid <= 1'b0;
        end else begin
            valid <= win_end;
            if (win_end) fault <= violation;
        end
    end
endmodule

// File: rtl/strobe_monitor.sv
// Top of the strobed supply divider monitor. It powers the divider and
// wakes the comparators for a short window each period and latches the
// selected comparator verdict at the window's end.
// Assumes us_tick is a single-cycle pulse and the inputs are synchronous.
module strobe_monitor
    import strobe_pkg::*;
#(
    parameter int PERIOD_TICKS = 10000,
    parameter int STROBE_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic mon_enable,
    input  logic gate_high,
    input  logic cmp_uv_lo,
    input  logic cmp_uv_hi,
    input  logic cmp_ov,
    output logic div_gnd_en,
    output logic cmp_wake,
    output logic volt_fault,
    output logic sample_valid
);
    logic        run;
    logic        window;
    logic        win_end;
    logic        violation;
    cmp_levels_t levels;

    // Bundle comparator levels
    always_comb levels = '{uv_lo: cmp_uv_lo, uv_hi: cmp_uv_hi, ov: cmp_ov};

    strobe_sequencer #(
        .PERIOD_TICKS(PERIOD_TICKS),
        .STROBE_TICKS(STROBE_TICKS)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .mon_enable(mon_enable),
        .run(run), .window(window), .win_end(win_end)
    );

    uv_fault_eval i_eval (
        .levels(levels), .gate_high(gate_high), .violation(violation)
    );

    fault_capture i_cap (
        .clk(clk), .rst_n(rst_n), .run(run), .win_end(win_end),
        .violation(violation), .fault(volt_fault), .valid(sample_valid)
    );

    // Ground switch and comparator wake share the window
    always_comb begin
        div_gnd_en = window;
        cmp_wake   = window;
    end
endmodule

// File: rtl/strobe_monitor_chk.sv
// Port-level assertions for strobe_monitor, attached with bind.
module strobe_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic mon_enable,
    input logic div_gnd_en,
    input logic volt_fault,
    input logic sample_valid
);
    // R9: the valid pulse never lasts two cycles
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R9: a valid pulse follows a cycle with the window open
    a_r9_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> $past(div_gnd_en));

    // R10: no window while the registered enable is low
    a_r10_idle_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mon_enable) |-> !div_gnd_en);

    // R10: the window opens in the first cycle after enable is registered
    a_r10_open_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mon_enable) && !$past(mon_enable, 2)) |-> div_gnd_en);

    // R8: a fault can only rise right after a window
    a_r8_rise_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(volt_fault) |-> $past(div_gnd_en));

    // R5: the fault changes only with a capture or an idle clear
    a_r5_change_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(volt_fault) |-> (sample_valid || !$past(mon_enable, 2)));
endmodule

bind strobe_monitor strobe_monitor_chk i_chk (.*);

// File: tb/test_strobe_monitor.sv
module test_strobe_monitor;
    localparam int P = 20;
    localparam int S = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b1;
    logic mon_enable = 1'b0;
    logic gate_high = 1'b0;
    logic cmp_uv_lo = 1'b1;
    logic cmp_uv_hi = 1'b1;
    logic cmp_ov = 1'b0;
    logic div_gnd_en, cmp_wake, volt_fault, sample_valid;

    int n_chk = 0;
    int n_fail = 0;
    int kcyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    strobe_monitor #(.PERIOD_TICKS(P), .STROBE_TICKS(S)) i_strobe_monitor (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .mon_enable(mon_enable),
        .gate_high(gate_high), .cmp_uv_lo(cmp_uv_lo), .cmp_uv_hi(cmp_uv_hi),
        .cmp_ov(cmp_ov), .div_gnd_en(div_gnd_en), .cmp_wake(cmp_wake),
        .volt_fault(volt_fault), .sample_valid(sample_valid)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at k=%0d: actual %b expected %b", req, kcyc, act, exp);
        end
    endtask

    // Advance one clock; inputs and samples sit 1 ns after the edge
    task automatic step();
        @(posedge clk);
        #1;
        kcyc++;
    endtask

    task automatic advance_to(input int t);
        while (kcyc < t) step();
    endtask

    // Drop enable, then raise it; on return kcyc = 0 is the first window cycle
    task automatic restart();
        mon_enable = 1'b0;
        step(); step();
        mon_enable = 1'b1;
        step();
        kcyc = 0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    task automatic t_reset();
        chk("R1 gnd", div_gnd_en, 1'b0);
        chk("R1 wake", cmp_wake, 1'b0);
        chk("R1 fault", volt_fault, 1'b0);
        chk("R1 valid", sample_valid, 1'b0);
    endtask

    // R2/R3/R9 window shape over two periods with clean levels
    task automatic t_window_period();
        restart();
        for (int k = 0; k < 2 * P + 1; k++) begin
            advance_to(k);
            chk("R2 gnd window", div_gnd_en, (k % P) < S);
            chk("R2 wake window", cmp_wake, (k % P) < S);
            chk("R9 valid pulse", sample_valid, (k % P) == S);
            chk("R3 clean fault", volt_fault, 1'b0);
        end
    endtask

    // R4: without ticks the window stays open and nothing is captured
    task automatic t_no_tick();
        mon_enable = 1'b0;
        step(); step();
        us_tick = 1'b0;
        cmp_ov = 1'b1;
        mon_enable = 1'b1;
        step();
        for (int i = 0; i < 3 * S; i++) begin
            chk("R4 window held", div_gnd_en, 1'b1);
            chk("R4 no capture", sample_valid, 1'b0);
            chk("R4 no fault", volt_fault, 1'b0);
            step();
        end
        cmp_ov = 1'b0;
        us_tick = 1'b1;
    endtask

    // R5/R7/R8: only the last window cycle counts; fault holds a period
    task automatic t_capture_edge();
        restart();
        cmp_ov = 1'b1;
        advance_to(S - 1);
        cmp_ov = 1'b0;
        advance_to(S);
        chk("R5 early level ignored", volt_fault, 1'b0);
        chk("R9 valid", sample_valid, 1'b1);
        cmp_ov = 1'b1;
        advance_to(S + 1);
        chk("R9 valid one cycle", sample_valid, 1'b0);
        advance_to(P + S - 1);
        chk("R5 outside level ignored", volt_fault, 1'b0);
        advance_to(P + S);
        chk("R7 ov captured", volt_fault, 1'b1);
        cmp_ov = 1'b0;
        advance_to(2 * P + S - 1);
        chk("R8 fault held", volt_fault, 1'b1);
        advance_to(2 * P + S);
        chk("R8 fault cleared", volt_fault, 1'b0);
    endtask

    // R6: UV comparator chosen by gate state
    task automatic t_gate_select();
        restart();
        gate_high = 1'b1; cmp_uv_lo = 1'b1; cmp_uv_hi = 1'b0;
        advance_to(S);
        chk("R6 gate on uses uv_lo", volt_fault, 1'b0);
        gate_high = 1'b0;
        advance_to(P + S);
        chk("R6 gate off uses uv_hi", volt_fault, 1'b1);
        cmp_uv_lo = 1'b0; cmp_uv_hi = 1'b1;
        advance_to(2 * P + S);
        chk("R6 gate off ignores uv_lo", volt_fault, 1'b0);
        gate_high = 1'b1;
        advance_to(3 * P + S);
        chk("R6 gate on uv_lo low", volt_fault, 1'b1);
        cmp_uv_lo = 1'b1;
    endtask

    // R10: disable releases, clears, and restarts from zero
    task automatic t_disable();
        chk("R10 precondition fault", volt_fault, 1'b1);
        advance_to(3 * P + 2);
        chk("R10 mid-period closed", div_gnd_en, 1'b0);
        mon_enable = 1'b0;
        step();
        chk("R10 window off", div_gnd_en, 1'b0);
        step();
        chk("R10 fault cleared", volt_fault, 1'b0);
        chk("R10 wake off", cmp_wake, 1'b0);
        mon_enable = 1'b1;
        step();
        kcyc = 0;
        chk("R10 window reopens", div_gnd_en, 1'b1);
        advance_to(S);
        chk("R10 length from zero", div_gnd_en, 1'b0);
        chk("R10 capture after restart", sample_valid, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_window_period();
        t_no_tick();
        t_capture_edge();
        t_gate_select();
        t_disable();
        finished = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule